// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits beside the execute stage of a five-stage in-order integer pipeline. Each cycle it takes the two source register numbers of the instruction about to execute. It compares them with the destination register numbers of the two older instructions still in flight: the one in the memory stage, whose ALU result waits in the execute/memory pipeline register, and the one in the write-back stage, held in the memory/write-back pipeline register. For each ALU operand it produces a two-bit source select and the routed 32-bit operand. An older instruction only supplies a value if it really writes a register and that register is not the hard-wired zero register.

The unit is purely combinational. Results produced at the end of one execute cycle can therefore feed the next instruction's execute cycle with no added delay. The write-back path carries whichever value that stage will commit: load data or the ALU result. When both older instructions target the same register, the newer one wins. Stalls for a load followed at once by its consumer are generated elsewhere. This unit only chooses among values that already exist.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage producer writes (write enable 1) a nonzero register equal to an operand's source register, that operand's select is 2'b10 and the operand equals the memory-stage ALU result.
- R2: When only the write-back-stage producer writes a nonzero register equal to an operand's source register, that operand's select is 2'b01.
- R3: With select 2'b01 the operand equals the write-back load data when the write-back memory-to-register flag is 1, and the write-back ALU result when it is 0.
- R4: When neither producer matches, the select is 2'b00 and the operand equals that operand's register-file read value.
- R5: A producer whose destination is register 0 never causes forwarding, even when the source register is also 0 and its write enable is 1.
- R6: A producer whose write enable is 0 never causes forwarding, even when its destination equals the source register.
- R7: When both producers match the same source register, the memory-stage producer is chosen (select 2'b10).
- R8: Operand A and operand B are resolved independently, and the select value 2'b11 is never produced.
- R9: Selects and operands follow input changes combinationally, with no clock edge between a change and its effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | Source register number of operand A in execute |
| src_b | input | 5 | Source register number of operand B in execute |
| rf_a | input | 32 | Register-file read value for operand A |
| rf_b | input | 32 | Register-file read value for operand B |
| xm_dst | input | 5 | Destination register of the memory-stage instruction |
| xm_wen | input | 1 | Register write enable of the memory-stage instruction |
| xm_res | input | 32 | ALU result held in the execute/memory register |
| mw_dst | input | 5 | Destination register of the write-back-stage instruction |
| mw_wen | input | 1 | Register write enable of the write-back-stage instruction |
| mw_ld_sel | input | 1 | 1: write-back commits load data; 0: commits ALU result |
| mw_res | input | 32 | ALU result held in the memory/write-back register |
| mw_ld_data | input | 32 | Load data held in the memory/write-back register |
| sel_a | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | 32 | Routed operand A |
| opnd_b | output | 32 | Routed operand B |

## Verification
The hardest case to reach is a double match, where both older instructions claim the same source register. On top of it sit the guards that must still suppress one or both paths. Real code rarely writes one register twice in a row and then reads it at once. The bench therefore drives the pipeline-register fields directly. It sets both destinations equal to a source, then clears one write enable or moves one destination to register 0, so that each guard and the priority rule are shown apart. Distinct data words on every value input make a wrong route visible in the operand output.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SRC_RF = 2'b00,
        SRC_WB = 2'b01,
        SRC_XM = 2'b10
    } src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_W = fwd_pkg::REG_W
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wen,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wen && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick (
    input  logic       hit_xm,
    input  logic       hit_wb,
    output logic [1:0] sel
);
    import fwd_pkg::*;

    always_comb begin
        if (hit_xm)      sel = SRC_XM;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux #(
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] xm_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);
    import fwd_pkg::*;

    always_comb begin
        case (sel)
            SRC_XM:  opnd = xm_val;
            SRC_WB:  opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int REG_W  = fwd_pkg::REG_W,
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [REG_W-1:0]  xm_dst,
    input  logic              xm_wen,
    input  logic [DATA_W-1:0] xm_res,
    input  logic [REG_W-1:0]  mw_dst,
    input  logic              mw_wen,
    input  logic              mw_ld_sel,
    input  logic [DATA_W-1:0] mw_res,
    input  logic [DATA_W-1:0] mw_ld_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0]  src_d  [NUM_SRC];
    logic [DATA_W-1:0] rf_d   [NUM_SRC];
    logic [1:0]        sel_d  [NUM_SRC];
    logic [DATA_W-1:0] opnd_d [NUM_SRC];
    logic [DATA_W-1:0] wb_val_d;

    // value the write-back stage is about to commit
    always_comb begin
        wb_val_d = mw_ld_sel ? mw_ld_data : mw_res;
    end

    always_comb begin
        src_d[0] = src_a;
        src_d[1] = src_b;
        rf_d[0]  = rf_a;
        rf_d[1]  = rf_b;
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        logic hit_xm;
        logic hit_wb;

        fwd_match #(.REG_W(REG_W)) u_m_xm (
            .src (src_d[k]),
            .dst (xm_dst),
            .wen (xm_wen),
            .hit (hit_xm)
        );

        fwd_match #(.REG_W(REG_W)) u_m_wb (
            .src (src_d[k]),
            .dst (mw_dst),
            .wen (mw_wen),
            .hit (hit_wb)
        );

        fwd_pick u_pick (
            .hit_xm (hit_xm),
            .hit_wb (hit_wb),
            .sel    (sel_d[k])
        );

        fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel    (sel_d[k]),
            .rf_val (rf_d[k]),
            .xm_val (xm_res),
            .wb_val (wb_val_d),
            .opnd   (opnd_d[k])
        );
    end

    always_comb begin
        sel_a  = sel_d[0];
        sel_b  = sel_d[1];
        opnd_a = opnd_d[0];
        opnd_b = opnd_d[1];
    end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W  = fwd_pkg::REG_W,
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input logic [REG_W-1:0]  src_a,
    input logic [REG_W-1:0]  src_b,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic [REG_W-1:0]  xm_dst,
    input logic              xm_wen,
    input logic [DATA_W-1:0] xm_res,
    input logic [REG_W-1:0]  mw_dst,
    input logic              mw_wen,
    input logic              mw_ld_sel,
    input logic [DATA_W-1:0] mw_res,
    input logic [DATA_W-1:0] mw_ld_data,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);
    always_comb begin
        p_xm_route_r1: assert (!(sel_a == 2'b10) || opnd_a == xm_res)
            else $error("operand A not memory-stage result");
        p_xm_route_b_r1: assert (!(sel_b == 2'b10) || opnd_b == xm_res)
            else $error("operand B not memory-stage result");
        p_wb_route_r3: assert (!(sel_a == 2'b01) ||
                               opnd_a == (mw_ld_sel ? mw_ld_data : mw_res))
            else $error("operand A not write-back value");
        p_wb_route_b_r3: assert (!(sel_b == 2'b01) ||
                                 opnd_b == (mw_ld_sel ? mw_ld_data : mw_res))
            else $error("operand B not write-back value");
        p_rf_route_r4: assert (!(sel_a == 2'b00) || opnd_a == rf_a)
            else $error("operand A not register file");
        p_rf_route_b_r4: assert (!(sel_b == 2'b00) || opnd_b == rf_b)
            else $error("operand B not register file");
        p_zero_guard_r5: assert (!((xm_dst == '0 || !xm_wen) &&
                                   (sel_a == 2'b10 || sel_b == 2'b10)))
            else $error("memory-stage forward without valid producer");
        p_zero_guard_wb_r5: assert (!((mw_dst == '0 || !mw_wen) &&
                                      (sel_a == 2'b01 || sel_b == 2'b01)))
            else $error("write-back forward without valid producer");
        p_prio_r7: assert (!(xm_wen && xm_dst != '0 && xm_dst == src_a) ||
                           sel_a == 2'b10)
            else $error("memory stage not preferred on A");
        p_prio_b_r7: assert (!(xm_wen && xm_dst != '0 && xm_dst == src_b) ||
                             sel_b == 2'b10)
            else $error("memory stage not preferred on B");
        p_legal_sel_r8: assert (sel_a != 2'b11 && sel_b != 2'b11)
            else $error("illegal select value");
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
    .src_a      (src_a),
    .src_b      (src_b),
    .rf_a       (rf_a),
    .rf_b       (rf_b),
    .xm_dst     (xm_dst),
    .xm_wen     (xm_wen),
    .xm_res     (xm_res),
    .mw_dst     (mw_dst),
    .mw_wen     (mw_wen),
    .mw_ld_sel  (mw_ld_sel),
    .mw_res     (mw_res),
    .mw_ld_data (mw_ld_data),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b)
);

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
    logic [4:0]  src_a, src_b, xm_dst, mw_dst;
    logic [31:0] rf_a, rf_b, xm_res, mw_res, mw_ld_data;
    logic        xm_wen, mw_wen, mw_ld_sel;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [31:0] V_RFA = 32'hA0A0_0001;
    localparam logic [31:0] V_RFB = 32'hB0B0_0002;
    localparam logic [31:0] V_XM  = 32'hC0DE_0003;
    localparam logic [31:0] V_MWA = 32'hD00D_0004;
    localparam logic [31:0] V_LD  = 32'hE1E1_0005;

    fwd_unit u0 (
        .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
        .xm_dst(xm_dst), .xm_wen(xm_wen), .xm_res(xm_res),
        .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_ld_sel(mw_ld_sel),
        .mw_res(mw_res), .mw_ld_data(mw_ld_data),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        src_a = 5'd0; src_b = 5'd0; rf_a = V_RFA; rf_b = V_RFB;
        xm_dst = 5'd0; xm_wen = 1'b0; xm_res = V_XM;
        mw_dst = 5'd0; mw_wen = 1'b0; mw_ld_sel = 1'b0;
        mw_res = V_MWA; mw_ld_data = V_LD;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_idle();
        idle(); settle();
        chk("R4 idle sel_a", {30'd0, sel_a}, 32'd0);
        chk("R4 idle sel_b", {30'd0, sel_b}, 32'd0);
        chk("R4 idle opnd_a", opnd_a, V_RFA);
        chk("R4 idle opnd_b", opnd_b, V_RFB);
    endtask

    task automatic t_xm();
        idle(); src_a = 5'd5; src_b = 5'd6; xm_dst = 5'd5; xm_wen = 1'b1; settle();
        chk("R1 sel_a", {30'd0, sel_a}, 32'd2);
        chk("R1 opnd_a", opnd_a, V_XM);
        chk("R8 sel_b untouched", {30'd0, sel_b}, 32'd0);
        chk("R8 opnd_b untouched", opnd_b, V_RFB);
    endtask

    task automatic t_wb_alu();
        idle(); src_b = 5'd7; mw_dst = 5'd7; mw_wen = 1'b1; mw_ld_sel = 1'b0; settle();
        chk("R2 sel_b", {30'd0, sel_b}, 32'd1);
        chk("R3 opnd_b alu", opnd_b, V_MWA);
        chk("R8 sel_a untouched", {30'd0, sel_a}, 32'd0);
    endtask

    task automatic t_wb_load();
        idle(); src_a = 5'd9; mw_dst = 5'd9; mw_wen = 1'b1; mw_ld_sel = 1'b1; settle();
        chk("R2 sel_a load", {30'd0, sel_a}, 32'd1);
        chk("R3 opnd_a load", opnd_a, V_LD);
    endtask

    task automatic t_zero();
        idle(); xm_wen = 1'b1; mw_wen = 1'b1; src_a = 5'd0; src_b = 5'd0; settle();
        chk("R5 sel_a zero", {30'd0, sel_a}, 32'd0);
        chk("R5 sel_b zero", {30'd0, sel_b}, 32'd0);
        chk("R5 opnd_a zero", opnd_a, V_RFA);
        // memory stage to r0, write-back valid on r3: write-back must serve
        xm_dst = 5'd0; mw_dst = 5'd3; src_a = 5'd3; settle();
        chk("R5 zero xm skipped", {30'd0, sel_a}, 32'd1);
    endtask

    task automatic t_wen();
        idle(); src_a = 5'd12; src_b = 5'd13; xm_dst = 5'd12; mw_dst = 5'd13; settle();
        chk("R6 sel_a no wen", {30'd0, sel_a}, 32'd0);
        chk("R6 sel_b no wen", {30'd0, sel_b}, 32'd0);
        chk("R6 opnd_b no wen", opnd_b, V_RFB);
    endtask

    task automatic t_prio();
        idle(); src_a = 5'd20; xm_dst = 5'd20; mw_dst = 5'd20;
        xm_wen = 1'b1; mw_wen = 1'b1; mw_ld_sel = 1'b1; settle();
        chk("R7 sel_a prio", {30'd0, sel_a}, 32'd2);
        chk("R7 opnd_a prio", opnd_a, V_XM);
        xm_wen = 1'b0; settle();
        chk("R7 fallback to wb", {30'd0, sel_a}, 32'd1);
        chk("R7 fallback opnd", opnd_a, V_LD);
    endtask

    task automatic t_split();
        idle(); src_a = 5'd4; src_b = 5'd8; xm_dst = 5'd4; mw_dst = 5'd8;
        xm_wen = 1'b1; mw_wen = 1'b1; settle();
        chk("R8 split sel_a", {30'd0, sel_a}, 32'd2);
        chk("R8 split sel_b", {30'd0, sel_b}, 32'd1);
        chk("R8 split opnd_b", opnd_b, V_MWA);
        src_b = 5'd4; settle();
        chk("R8 same src both", {28'd0, sel_a, sel_b}, 32'hA);
    endtask

    task automatic t_far();
        idle(); src_a = 5'd15; src_b = 5'd16; xm_dst = 5'd17; mw_dst = 5'd18;
        xm_wen = 1'b1; mw_wen = 1'b1; settle();
        chk("R4 far sel", {28'd0, sel_a, sel_b}, 32'h0);
        chk("R4 far opnd_a", opnd_a, V_RFA);
    endtask

    task automatic t_comb();
        idle(); src_a = 5'd2; xm_dst = 5'd2; xm_wen = 1'b1; settle();
        #1 xm_res = 32'h1234_5678;
        #1;
        chk("R9 comb follow", opnd_a, 32'h1234_5678);
        #1 xm_wen = 1'b0;
        #1;
        chk("R9 comb drop", opnd_a, V_RFA);
    endtask

    initial begin
        idle();
        t_idle();
        t_xm();
        t_wb_alu();
        t_wb_load();
        t_zero();
        t_wen();
        t_prio();
        t_split();
        t_far();
        t_comb();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule